// File: doc/BRIEF.md
# Partitioned 8x16 Multiplier

This unit multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in four parallel lanes. Each lane forms the full signed product, keeps bits 23:8 of it and adds one when bit 7 is set. The rounding is round-half-up, and the 16-bit result wraps. A 3-bit mode code chooses which bytes and coefficients are taken from the two 64-bit operands and where the lane results go in the 64-bit output.

An operation is presented by raising `in_valid` with `mode`, `opa` and `opb` for one cycle. The result and `out_valid` appear on the next clock edge. While `in_valid` is low, `out_valid` drops and `result` keeps its last value. Operand fetch and instruction decode belong to the surrounding pipeline.

Top module: `pmul8x16_unit`

## Requirements
- R1: Every lane multiplies an unsigned 8-bit value `a` by a signed 16-bit value `b` and yields bits 23:8 of the signed product, plus one when product bit 7 is set.
- R2: Mode 0 (basic): for lane i in 0..3, byte `opa[8i+7:8i]` multiplies `opb[16i+15:16i]`, and the result goes to `result[16i+15:16i]`.
- R3: Modes 1 and 2 (alpha): all four bytes `opa[8i+7:8i]` multiply one coefficient. Mode 1 takes it from `opb[31:16]` and mode 2 from `opb[15:0]`. Lane i result goes to `result[16i+15:16i]`.
- R4: Modes 3 and 4 (byte select): lane i takes `opa[16i+15:16i+8]` (mode 3) or `opa[16i+7:16i]` (mode 4) and multiplies `opb[16i+15:16i]`. The result goes to `result[16i+15:16i]`.
- R5: Modes 5 and 6 (double): only lanes 0 and 1 are computed. They use the upper (mode 5) or lower (mode 6) byte of `opa[16i+15:16i]` and the coefficient `opb[16i+15:16i]`. Lane i result is placed at `result[32i+22:32i+7]`, and every other result bit is zero.
- R6: The rounding increment wraps within 16 bits and never saturates. For example, a=1 with b=0xFFFF gives 0x0000.
- R7: Mode 7 is reserved. It produces an all-zero result with `out_valid` set.
- R8: `out_valid` equals `in_valid` of the previous cycle. While `in_valid` is low, `result` holds its previous value.
- R9: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| mode | input | 3 | Operand selection and placement code (0..7) |
| opa | input | 64 | Pixel byte operand |
| opb | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered lane results |

## Verification
The hardest cases to reach are at the rounding boundary. These are products whose bit 7 is set while bits 23:8 are all ones, so the increment wraps. They need a negative coefficient paired with a small pixel value, and random operands rarely produce them. The stimulus therefore mixes random traffic with directed lanes: coefficients 0xFFFF, 0x8000, 0x7FFF and 0x0080 against pixel values 0x01 and 0xFF. The directed cases run in every mode, so each operand-selection path sees the wrap case. The double modes are fed nonzero upper operand halves to show that those bits stay out of the result.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [2:0] {
        MODE_BASIC    = 3'd0,
        MODE_ALPHA_HI = 3'd1,
        MODE_ALPHA_LO = 3'd2,
        MODE_BYTE_HI  = 3'd3,
        MODE_BYTE_LO  = 3'd4,
        MODE_DBL_HI   = 3'd5,
        MODE_DBL_LO   = 3'd6,
        MODE_RSVD     = 3'd7
    } pmul_mode_e;

    function automatic logic is_double(input pmul_mode_e m);
        return (m == MODE_DBL_HI) || (m == MODE_DBL_LO);
    endfunction

endpackage

// File: rtl/pmul_lane_sel.sv
module pmul_lane_sel
    import pmul_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 8,
    parameter int BW    = 16
) (
    input  logic [2:0]          mode,
    input  logic [LANES*BW-1:0] opa,
    input  logic [LANES*BW-1:0] opb,
    output logic [LANES*AW-1:0] lane_a,
    output logic [LANES*BW-1:0] lane_b
);
    localparam int DBL_LANES = LANES / 2;
    localparam int HI_OFS    = BW - AW;

    pmul_mode_e m;
    assign m = pmul_mode_e'(mode);

    always_comb begin
        lane_a = '0;
        lane_b = '0;
        for (int i = 0; i < LANES; i++) begin
            unique case (m)
                MODE_BASIC: begin
                    lane_a[i*AW +: AW] = opa[i*AW +: AW];
                    lane_b[i*BW +: BW] = opb[i*BW +: BW];
                end
                MODE_ALPHA_HI: begin
                    lane_a[i*AW +: AW] = opa[i*AW +: AW];
                    lane_b[i*BW +: BW] = opb[BW +: BW];
                end
                MODE_ALPHA_LO: begin
                    lane_a[i*AW +: AW] = opa[i*AW +: AW];
                    lane_b[i*BW +: BW] = opb[0 +: BW];
                end
                MODE_BYTE_HI: begin
                    lane_a[i*AW +: AW] = opa[i*BW + HI_OFS +: AW];
                    lane_b[i*BW +: BW] = opb[i*BW +: BW];
                end
                MODE_BYTE_LO: begin
                    lane_a[i*AW +: AW] = opa[i*BW +: AW];
                    lane_b[i*BW +: BW] = opb[i*BW +: BW];
                end
                MODE_DBL_HI: begin
                    if (i < DBL_LANES) begin
                        lane_a[i*AW +: AW] = opa[i*BW + HI_OFS +: AW];
                        lane_b[i*BW +: BW] = opb[i*BW +: BW];
                    end
                end
                MODE_DBL_LO: begin
                    if (i < DBL_LANES) begin
                        lane_a[i*AW +: AW] = opa[i*BW +: AW];
                        lane_b[i*BW +: BW] = opb[i*BW +: BW];
                    end
                end
                default: begin
                    lane_a[i*AW +: AW] = '0;
                    lane_b[i*BW +: BW] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pmul_lane_mul.sv
module pmul_lane_mul #(
    parameter int AW = 8,
    parameter int BW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [BW-1:0] y
);
    localparam int PW   = AW + BW + 1;
    localparam int KEEP = AW;

    logic signed [AW:0]   a_s;
    logic signed [BW-1:0] b_s;
    logic signed [PW-1:0] prod;

    always_comb begin
        a_s  = $signed({1'b0, a});
        b_s  = $signed(b);
        prod = PW'(a_s) * PW'(b_s);
        y    = prod[KEEP +: BW] + BW'(prod[KEEP-1]);
    end

endmodule

// File: rtl/pmul_place.sv
module pmul_place
    import pmul_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 8,
    parameter int BW    = 16
) (
    input  logic [2:0]          mode,
    input  logic [LANES*BW-1:0] lane_y,
    output logic [LANES*BW-1:0] placed
);
    localparam int DBL_LANES  = LANES / 2;
    localparam int DBL_STRIDE = 2 * BW;
    localparam int DBL_OFS    = AW - 1;

    pmul_mode_e m;
    assign m = pmul_mode_e'(mode);

    always_comb begin
        placed = '0;
        if (m == MODE_RSVD) begin
            placed = '0;
        end else if (is_double(m)) begin
            for (int i = 0; i < DBL_LANES; i++) begin
                placed[i*DBL_STRIDE + DBL_OFS +: BW] = lane_y[i*BW +: BW];
            end
        end else begin
            placed = lane_y;
        end
    end

endmodule

// File: rtl/pmul8x16_unit.sv
module pmul8x16_unit
    import pmul_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 8,
    parameter int BW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          mode,
    input  logic [LANES*BW-1:0] opa,
    input  logic [LANES*BW-1:0] opb,
    output logic                out_valid,
    output logic [LANES*BW-1:0] result
);
    localparam int DW = LANES * BW;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [LANES*AW-1:0] lane_a;
    logic [LANES*BW-1:0] lane_b;
    logic [LANES*BW-1:0] lane_y;
    logic [DW-1:0]       placed;

    pmul_lane_sel #(.LANES(LANES), .AW(AW), .BW(BW)) u_sel (
        .mode   (mode),
        .opa    (opa),
        .opb    (opb),
        .lane_a (lane_a),
        .lane_b (lane_b)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmul_lane_mul #(.AW(AW), .BW(BW)) u_mul (
            .a (lane_a[g*AW +: AW]),
            .b (lane_b[g*BW +: BW]),
            .y (lane_y[g*BW +: BW])
        );
    end

    pmul_place #(.LANES(LANES), .AW(AW), .BW(BW)) u_place (
        .mode   (mode),
        .lane_y (lane_y),
        .placed (placed)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = placed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;

endmodule

// File: rtl/pmul8x16_chk.sv
module pmul8x16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  mode,
    input logic [63:0] opb,
    input logic        out_valid,
    input logic [63:0] result
);
    // R8: valid follows the request by one cycle
    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R8: result holds while idle
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R5: double modes leave bits outside both placed fields at zero
    assert_dbl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 3'd5 || mode == 3'd6)) |=>
        (result[6:0] == 7'd0 && result[38:23] == 16'd0 && result[63:55] == 9'd0));

    // R7: reserved code gives zero
    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd7) |=> (out_valid && result == 64'd0));

    // R3: a zero alpha coefficient zeroes every lane
    assert_alpha_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((mode == 3'd1 && opb[31:16] == 16'd0) ||
                      (mode == 3'd2 && opb[15:0] == 16'd0))) |=> (result == 64'd0));

    // R9: reset leaves the outputs cleared
    always @(posedge clk) begin
        if (rst_n && !$isunknown(out_valid)) begin
            assert_reset_clear_R9: assert (!($past(rst_n) == 1'b0) || (!out_valid && result == 64'd0));
        end
    end

endmodule

bind pmul8x16_unit pmul8x16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_pmul8x16_unit.sv
`timescale 1ns/1ps
module sim_pmul8x16_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pmul8x16_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    // R1, R6: behavioural lane arithmetic on integers
    function automatic logic [15:0] lane_ref(input logic [7:0] a, input logic [15:0] b);
        int sa, sb, p;
        logic [31:0] pv;
        sa = int'(a);
        sb = int'($signed(b));
        p  = sa * sb;
        pv = p;
        return 16'((p >>> 8) + int'(pv[7]));
    endfunction

    function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        case (m)
            3'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[8*i +: 8], b[16*i +: 16]);
            3'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[8*i +: 8], b[31:16]);
            3'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[8*i +: 8], b[15:0]);
            3'd3: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[16*i+8 +: 8], b[16*i +: 16]);
            3'd4: for (int i = 0; i < 4; i++) r[16*i +: 16] = lane_ref(a[16*i +: 8], b[16*i +: 16]);
            3'd5: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = lane_ref(a[16*i+8 +: 8], b[16*i +: 16]);
            3'd6: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = lane_ref(a[16*i +: 8], b[16*i +: 16]);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1, 3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            default: return "R7";
        endcase
    endfunction

    // Reference model state, advanced on every clock
    logic        exp_v = 1'b0;
    logic [63:0] exp_d = '0;
    string       exp_tag = "R9";

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v   <= 1'b0;
            exp_d   <= '0;
            exp_tag <= "R9";
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_d   <= model(mode, opa, opb);
                exp_tag <= mode_tag(mode);
            end else begin
                exp_tag <= "R8";
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (out_valid !== exp_v) begin
                n_fails++;
                $display("FAIL R8 out_valid got %0b exp %0b", out_valid, exp_v);
            end
            n_checks++;
            if (result !== exp_d) begin
                n_fails++;
                $display("FAIL %s result got %h exp %h", exp_tag, result, exp_d);
            end
        end
    end

    task automatic issue(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = m; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic directed(input string tag, input logic [2:0] m, input logic [63:0] a,
                            input logic [63:0] b, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; mode = m; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        n_checks++;
        if (result !== exp || out_valid !== 1'b1) begin
            n_fails++;
            $display("FAIL %s directed got %h/%0b exp %h/1", tag, result, out_valid, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        n_checks++;
        if (out_valid !== 1'b0 || result !== 64'd0) begin
            n_fails++;
            $display("FAIL R9 reset got %h/%0b exp 0/0", result, out_valid);
        end
        rst_n = 1'b1;

        // R1/R2/R6: lanes 7F7F, 0001 (round up), 0000 (wrap), 8080
        directed("R1", 3'd0, 64'h0000_0000_FF01_01FF, 64'h8000_FFFF_0080_7FFF, 64'h8080_0000_0001_7F7F);
        directed("R6", 3'd0, 64'h0000_0000_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000);
        // R3: upper alpha coefficient 0x0100 -> each byte passes through
        directed("R3", 3'd1, 64'h0000_0000_0403_0201, 64'h0000_0000_0100_7777, 64'h0004_0003_0002_0001);
        directed("R3", 3'd2, 64'h0000_0000_0403_0201, 64'h0000_0000_7777_0100, 64'h0004_0003_0002_0001);
        // R4: byte select
        directed("R4", 3'd3, 64'h0400_0300_0200_0100, 64'h0100_0100_0100_0100, 64'h0004_0003_0002_0001);
        directed("R4", 3'd4, 64'h0004_0003_0002_0001, 64'h0100_0100_0100_0100, 64'h0004_0003_0002_0001);
        // R5: double placement at bits 7 and 39
        directed("R5", 3'd5, 64'hFFFF_FFFF_0300_0200, 64'hFFFF_FFFF_0100_0100, 64'h0000_0180_0000_0100);
        directed("R5", 3'd6, 64'hFFFF_FFFF_0003_0002, 64'hFFFF_FFFF_0100_0100, 64'h0000_0180_0000_0100);
        // R7: reserved code
        directed("R7", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'd0);
        // R8: idle cycles hold the last result (compared every clock)
        repeat (3) @(negedge clk);

        // boundary coefficients in every mode
        for (int m = 0; m < 8; m++) begin
            issue(3'(m), 64'hFF01_FF01_01FF_01FF, 64'hFFFF_8000_7FFF_0080);
            issue(3'(m), 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF);
        end

        // random traffic with gaps
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 3) != 0);
            mode     = 3'($urandom_range(0, 7));
            opa      = {$urandom, $urandom};
            opb      = {$urandom, $urandom};
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule